// File: doc/BRIEF.md
# Serial Bit-Rate Strobe Generator

This block turns several free-running tick sources into the bit-advance strobes that a classic four-mode serial port needs. The sources are an oscillator-derived tick, the overflow pulse of the first timer and the overflow pulse of the second timer. A two-bit mode, a rate-doubling bit and two per-direction source-select bits control it. Its output is one transmit strobe and one receive strobe. Each strobe marks the moment the matching shift path should move on by one bit.

The transmit and receive directions each have their own accumulator. An accumulator counts only the ticks from its selected source, and only while its direction reports it is busy. When the count reaches the active divisor, the accumulator subtracts the divisor and emits a single strobe, so any surplus is kept. Dropping the busy flag clears the accumulator.

Top module: `bit_tick_sel`

## Requirements
- R1: While `rst` is high, both strobes are low and both accumulators are cleared. After reset, a full divisor of ticks is needed before the first strobe.
- R2: In mode 0 (`mode` = 2'b00), each path counts `osc_tick` pulses with a divisor of 12. `rate_dbl` has no effect in this mode.
- R3: In modes 1 (2'b01) and 3 (2'b11), the divisor is 16 when `rate_dbl` is 1 and 32 when it is 0.
- R4: In modes 1 and 3, the transmit path counts `t2_ovf` when `tx_use_t2` is 1 and `t1_ovf` when it is 0.
- R5: In modes 1 and 3, the receive path counts `t2_ovf` when `rx_use_t2` is 1 and `t1_ovf` when it is 0, regardless of `tx_use_t2`.
- R6: In mode 2 (2'b10), each path counts `osc_tick` pulses, with a divisor of 16 when `rate_dbl` is 1 and 32 when it is 0.
- R7: A path's accumulator advances only while that path's busy input is high. A cycle with busy low clears the accumulator and produces no strobe on that path.
- R8: A counted tick that brings the accumulator to the divisor or beyond sets the accumulator to the excess (sum minus divisor) and issues a strobe. The surplus left when the divisor shrinks is therefore carried into the next bit.
- R9: A strobe is a registered pulse one clock wide. It is high in the cycle after the clock edge that counted the completing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Serial mode 0..3 |
| rate_dbl | input | 1 | Rate doubling: selects divisor 16 instead of 32 in modes 1..3 |
| tx_use_t2 | input | 1 | Transmit source is second timer (modes 1, 3) |
| rx_use_t2 | input | 1 | Receive source is second timer (modes 1, 3) |
| osc_tick | input | 1 | Oscillator-derived tick pulse |
| t1_ovf | input | 1 | First timer overflow pulse |
| t2_ovf | input | 1 | Second timer overflow pulse |
| tx_busy | input | 1 | Transmit path active |
| rx_busy | input | 1 | Receive path active |
| tx_strobe | output | 1 | Transmit bit-advance strobe |
| rx_strobe | output | 1 | Receive bit-advance strobe |

## Verification
The bench walks every combination of mode, doubling bit and the two select bits. It feeds three independent random tick streams so that a path wired to the wrong source produces strobes at the wrong rate, and it compares both strobes with an arithmetic model on every cycle. Directed cases target the places where a design is most likely to go wrong:
- Shrinking the divisor in mid-bit catches a design that zeroes the accumulator on overflow instead of keeping the excess. Such a design strobes late.
- A one-cycle idle gap catches a design that keeps stale counts. Such a design strobes early.
- Crossed select bits catch a receive path that follows the transmit select by mistake.
- The exact strobe counts over a fixed number of ticks separate a swapped 16/32 divisor from an off-by-one compare.

// File: rtl/bit_tick_pkg.sv
package bit_tick_pkg;
  typedef enum logic [1:0] {
    SER_SHIFT  = 2'b00,
    SER_VAR8   = 2'b01,
    SER_FIXED9 = 2'b10,
    SER_VAR9   = 2'b11
  } ser_mode_e;

  function automatic logic mode_uses_timer(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/tick_route.sv
module tick_route
  import bit_tick_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       use_t2,
  input  logic       osc_tick,
  input  logic       t1_ovf,
  input  logic       t2_ovf,
  output logic       tick
);
  always_comb begin
    if (mode_uses_timer(mode)) tick = use_t2 ? t2_ovf : t1_ovf;
    else                       tick = osc_tick;
  end
endmodule

// File: rtl/bit_accum.sv
module bit_accum #(
  parameter int ACC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             tick,
  input  logic [ACC_W-1:0] div,
  output logic             strobe
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] div_ext;

  assign sum     = {1'b0, acc_q} + SUM_W'(1);
  assign div_ext = {1'b0, div};

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      acc_q  <= '0;
      strobe <= 1'b0;
    end else if (tick) begin
      if (sum >= div_ext) begin
        acc_q  <= ACC_W'(sum - div_ext);
        strobe <= 1'b1;
      end else begin
        acc_q  <= ACC_W'(sum);
        strobe <= 1'b0;
      end
    end else begin
      strobe <= 1'b0;
    end
  end

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !strobe);
  assert_one_wide_R9: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  assert_tick_needed_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !strobe);
endmodule

// File: rtl/bit_tick_sel.sv
module bit_tick_sel
  import bit_tick_pkg::*;
#(
  parameter int DIV_SHIFT = 12,
  parameter int DIV_FAST  = 16,
  parameter int DIV_SLOW  = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       rate_dbl,
  input  logic       tx_use_t2,
  input  logic       rx_use_t2,
  input  logic       osc_tick,
  input  logic       t1_ovf,
  input  logic       t2_ovf,
  input  logic       tx_busy,
  input  logic       rx_busy,
  output logic       tx_strobe,
  output logic       rx_strobe
);
  localparam int ACC_W  = $clog2(DIV_SLOW + 1);
  localparam int NPATH  = 2;

  logic [ACC_W-1:0] div;
  logic [NPATH-1:0] sel_t2, busy, tick, strobe;

  always_comb begin
    if (ser_mode_e'(mode) == SER_SHIFT) div = ACC_W'(DIV_SHIFT);
    else if (rate_dbl)                  div = ACC_W'(DIV_FAST);
    else                                div = ACC_W'(DIV_SLOW);
  end

  assign sel_t2 = {rx_use_t2, tx_use_t2};
  assign busy   = {rx_busy, tx_busy};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    tick_route u_route (
      .mode     (mode),
      .use_t2   (sel_t2[p]),
      .osc_tick (osc_tick),
      .t1_ovf   (t1_ovf),
      .t2_ovf   (t2_ovf),
      .tick     (tick[p])
    );
    bit_accum #(.ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .busy   (busy[p]),
      .tick   (tick[p]),
      .div    (div),
      .strobe (strobe[p])
    );
  end

  assign tx_strobe = strobe[0];
  assign rx_strobe = strobe[1];

  // R2 and R6: oscillator modes ignore both timers
  assert_osc_modes_R2: assert property (@(posedge clk) disable iff (rst)
    (!mode[0] && !osc_tick) |=> (!tx_strobe && !rx_strobe));
  assert_tx_source_R4: assert property (@(posedge clk) disable iff (rst)
    (mode[0] && !(tx_use_t2 ? t2_ovf : t1_ovf)) |=> !tx_strobe);
  assert_rx_source_R5: assert property (@(posedge clk) disable iff (rst)
    (mode[0] && !(rx_use_t2 ? t2_ovf : t1_ovf)) |=> !rx_strobe);
endmodule

// File: tb/bit_tick_sel_test.sv
module bit_tick_sel_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic rate_dbl = 1'b0, tx_use_t2 = 1'b0, rx_use_t2 = 1'b0;
  logic osc_tick = 1'b0, t1_ovf = 1'b0, t2_ovf = 1'b0;
  logic tx_busy = 1'b0, rx_busy = 1'b0;
  logic tx_strobe, rx_strobe;

  int n_cmp = 0, n_bad = 0;
  int macc [2];
  bit mstb [2];
  bit prev_stb [2];
  int cnt_tx = 0, cnt_rx = 0;
  bit done = 0;

  bit_tick_sel uut (
    .clk(clk), .rst(rst), .mode(mode), .rate_dbl(rate_dbl),
    .tx_use_t2(tx_use_t2), .rx_use_t2(rx_use_t2), .osc_tick(osc_tick),
    .t1_ovf(t1_ovf), .t2_ovf(t2_ovf), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .tx_strobe(tx_strobe), .rx_strobe(rx_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_div();
    if (mode == 2'd0) return 12;
    return rate_dbl ? 16 : 32;
  endfunction

  function automatic bit exp_tick(input int p);
    bit s;
    s = (p == 0) ? tx_use_t2 : rx_use_t2;
    if (!mode[0]) return osc_tick;
    return s ? t2_ovf : t1_ovf;
  endfunction

  function automatic string tag(input int p);
    bit b;
    b = (p == 0) ? tx_busy : rx_busy;
    if (rst) return "R1";
    if (!b) return "R7";
    if (mode == 2'd0) return "R2";
    if (mode == 2'd2) return "R6";
    return (p == 0) ? "R4" : "R5";
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit o, input bit a, input bit b);
    string tg [2];
    bit act [2];
    osc_tick = o; t1_ovf = a; t2_ovf = b;
    tg[0] = tag(0); tg[1] = tag(1);
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      bit bz;
      bz = (p == 0) ? tx_busy : rx_busy;
      if (rst || !bz) begin macc[p] = 0; mstb[p] = 0; end
      else if (exp_tick(p)) begin
        macc[p]++;
        if (macc[p] >= exp_div()) begin macc[p] -= exp_div(); mstb[p] = 1; end
        else mstb[p] = 0;
      end else mstb[p] = 0;
    end
    @(negedge clk);
    act[0] = tx_strobe; act[1] = rx_strobe;
    check(tg[0], int'(act[0]), int'(mstb[0]), "tx_strobe");
    check(tg[1], int'(act[1]), int'(mstb[1]), "rx_strobe");
    for (int p = 0; p < 2; p++) begin
      if (prev_stb[p] && act[p]) check("R9", 1, 0, "strobe wider than one cycle");
      prev_stb[p] = act[p];
    end
    cnt_tx += int'(act[0]);
    cnt_rx += int'(act[1]);
  endtask

  task automatic clear_paths();
    tx_busy = 0; rx_busy = 0;
    cyc(0, 0, 0);
    tx_busy = 1; rx_busy = 1;
    cnt_tx = 0; cnt_rx = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    macc[0] = 0; macc[1] = 0; mstb[0] = 0; mstb[1] = 0;
    prev_stb[0] = 0; prev_stb[1] = 0;
    @(negedge clk);
    // R1: reset holds strobes low despite busy and ticks
    rst = 1; tx_busy = 1; rx_busy = 1;
    for (int i = 0; i < 3; i++) cyc(1, 1, 1);
    check("R1", int'(tx_strobe), 0, "tx_strobe in reset");
    check("R1", int'(rx_strobe), 0, "rx_strobe in reset");
    rst = 0;
    cnt_tx = 0;
    for (int i = 0; i < 11; i++) cyc(1, 0, 0);
    check("R1", cnt_tx, 0, "strobes after 11 ticks from reset");
    cyc(1, 0, 0);
    check("R1", cnt_tx, 1, "strobes after 12 ticks from reset");

    // sweep of every configuration with random tick streams
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int ts = 0; ts < 2; ts++)
          for (int rs = 0; rs < 2; rs++) begin
            mode = 2'(m); rate_dbl = d[0]; tx_use_t2 = ts[0]; rx_use_t2 = rs[0];
            clear_paths();
            for (int i = 0; i < 150; i++) begin
              tx_busy = ($urandom_range(0, 39) != 0);
              rx_busy = ($urandom_range(0, 39) != 0);
              cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)));
            end
          end

    // R3: divisor 32 then 16 on the first timer
    mode = 2'd1; tx_use_t2 = 0; rx_use_t2 = 0;
    rate_dbl = 0; clear_paths();
    for (int i = 0; i < 64; i++) cyc(0, 1, 0);
    check("R3", cnt_tx, 2, "tx strobes, 64 ticks div 32");
    rate_dbl = 1; clear_paths();
    for (int i = 0; i < 64; i++) cyc(0, 1, 0);
    check("R3", cnt_tx, 4, "tx strobes, 64 ticks div 16");

    // R4 and R5: crossed timer selection in mode 3
    mode = 2'd3; tx_use_t2 = 1; rx_use_t2 = 0; rate_dbl = 1; clear_paths();
    for (int i = 0; i < 32; i++) cyc(1, 0, 1);
    check("R4", cnt_tx, 2, "tx strobes from second timer");
    check("R5", cnt_rx, 0, "rx strobes with first timer idle");

    // R6: mode 2 ignores timers, uses oscillator
    mode = 2'd2; rate_dbl = 1; clear_paths();
    for (int i = 0; i < 32; i++) cyc(1, 1, 1);
    check("R6", cnt_rx, 2, "rx strobes mode 2 div 16");

    // R2: mode 0 ignores rate_dbl
    mode = 2'd0; rate_dbl = 0; clear_paths();
    for (int i = 0; i < 24; i++) cyc(1, 0, 0);
    check("R2", cnt_tx, 2, "tx strobes mode 0, 24 ticks");

    // R7: idle gap clears the count
    clear_paths();
    for (int i = 0; i < 11; i++) cyc(1, 0, 0);
    tx_busy = 0; cyc(1, 0, 0); tx_busy = 1;
    for (int i = 0; i < 11; i++) cyc(1, 0, 0);
    check("R7", cnt_tx, 0, "tx strobes after idle gap");
    cyc(1, 0, 0);
    check("R7", cnt_tx, 1, "tx strobe on 12th tick after gap");

    // R8: excess carried when divisor shrinks
    mode = 2'd1; tx_use_t2 = 0; rate_dbl = 0; clear_paths();
    for (int i = 0; i < 20; i++) cyc(0, 1, 0);
    check("R8", cnt_tx, 0, "tx strobes after 20 of 32");
    rate_dbl = 1;
    cyc(0, 1, 0);
    check("R8", int'(tx_strobe), 1, "strobe on shrink");
    for (int i = 0; i < 10; i++) cyc(0, 1, 0);
    check("R8", cnt_tx, 1, "no strobe while carry builds");
    cyc(0, 1, 0);
    check("R8", cnt_tx, 2, "strobe after 11 more ticks");

    // R9: continuous ticks give isolated pulses
    mode = 2'd0; clear_paths();
    for (int i = 0; i < 12; i++) cyc(1, 0, 0);
    check("R9", int'(tx_strobe), 1, "strobe in cycle after 12th tick");
    cyc(1, 0, 0);
    check("R9", int'(tx_strobe), 0, "strobe dropped next cycle");

    finish_run();
  end
endmodule